// File: doc/BRIEF.md
# Shared-Timebase Sawtooth PWM Bank

This block drives a bank of pulse-width modulated outputs that all share one free-running up-counter. The counter steps by one on each clock edge while the enable input is high and rolls from its top value back to zero. Every 256-count period of the default build is one PWM period.

Each channel has its own duty level input. A channel does not compare magnitudes. Its output is a flag that is set on the enabled edge where the shared counter reads zero, and cleared on the enabled edge where the counter equals the channel's level. When both happen on the same edge, the set wins.

The level is sampled into a per-channel shadow register on the wrap edge. A level that changes partway through a period therefore only takes effect from the start of the next period. The levels come from outside the block, for example from a waveform table.

Top module: `pwm_bank`

## Requirements
- R1: On every rising clock edge with `enable` high, `countOut` increases by one, and it rolls over from 255 to 0.
- R2: While `rst` is high, `countOut`, every bit of `pwmOut` and every captured level are 0. The clear is asynchronous: it does not wait for a clock edge.
- R3: On a rising edge with `enable` low, `countOut` and `pwmOut` keep their values.
- R4: On an enabled edge where `countOut` is 0, every bit of `pwmOut` becomes 1.
- R5: On an enabled edge where `countOut` equals a channel's captured level and is not 0, that channel's bit becomes 0.
- R6: A channel whose captured level is 0 stays at 1 continuously from the first wrap edge on.
- R7: A channel's level is taken from bits [8*i+7:8*i] of `levels` on the enabled edge where `countOut` is 0. A change at any other time only applies from the next period.
- R8: From the first wrap on, for a captured level L in 1..255, `pwmOut[i]` is 1 exactly when `countOut` lies in 1..L. The output is therefore high for L enabled counts in every 256-count period.
- R9: Channels are independent: each bit of `pwmOut` depends only on the shared counter and its own level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| enable | input | 1 | Allows the counter and the outputs to advance |
| levels | input | 64 | Packed per-channel duty levels, channel i at bits [8*i+7:8*i] |
| pwmOut | output | 8 | One PWM bit per channel |
| countOut | output | 8 | Shared sawtooth counter value |

## Verification
The bound checker watches these rules on every cycle:
- the counter steps and wraps while enabled (R1);
- the counter and outputs hold still while enable is low (R3);
- reset clears all state (R2);
- every channel rises only on an enabled wrap edge (R4);
- every channel falls only on an enabled edge at a nonzero count (R5).

Some behaviour depends on the captured level, which the checker cannot see. The directed scenarios show it by comparing each output against a model that computes the expected value from the counter and the level:
- exact duty (R8);
- level-zero constant high (R6);
- deferred level pickup (R7);
- channel independence (R9);
- the asynchronous reset.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Strobes sent from the counter control to the channel datapath
  typedef struct packed {
    logic step;   // an enabled edge is coming
    logic wrap;   // the enabled edge happens with the counter at zero
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_bank_ctrl.sv
module pwm_bank_ctrl
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  output logic [CNT_W-1:0] cnt,
  output pwmStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic atZero;

  assign atZero = (cnt == CNT_ZERO);

  // Free-running sawtooth: plain binary rollover at the top value
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt <= CNT_ZERO;
    end else if (enable) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  always_comb begin
    strobe.step = enable;
    strobe.wrap = enable && atZero;
  end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pwmStrobe_t              strobe,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [NUM_CH*CNT_W-1:0] levels,
  output logic [NUM_CH-1:0]       pwm
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CNT_W-1:0] shadowLevel;
    logic             hitLevel;

    assign hitLevel = (cnt == shadowLevel);

    // Level is only taken at the period boundary
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        shadowLevel <= '0;
      end else if (strobe.wrap) begin
        shadowLevel <= levels[ch*CNT_W +: CNT_W];
      end
    end

    // Set at wrap (has priority), clear on exact match with the level
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        pwm[ch] <= 1'b0;
      end else if (strobe.wrap) begin
        pwm[ch] <= 1'b1;
      end else if (strobe.step && hitLevel) begin
        pwm[ch] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    enable,
  input  logic [NUM_CH*CNT_W-1:0] levels,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [CNT_W-1:0]        countOut
);

  pwmStrobe_t       strobe;
  logic [CNT_W-1:0] cnt;

  pwm_bank_ctrl #(.CNT_W(CNT_W)) ctrlInst (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .cnt    (cnt),
    .strobe (strobe)
  );

  pwm_bank_chan #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chanInst (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .cnt    (cnt),
    .levels (levels),
    .pwm    (pwmOut)
  );

  assign countOut = cnt;

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    enable,
  input logic [NUM_CH*CNT_W-1:0] levels,
  input logic [NUM_CH-1:0]       pwmOut,
  input logic [CNT_W-1:0]        countOut
);

  logic [NUM_CH*CNT_W-1:0] levelsSeen;
  assign levelsSeen = levels;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    enable |=> countOut == CNT_W'($past(countOut) + 1'b1));

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !enable |=> ($stable(countOut) && $stable(pwmOut)));

  assert_reset_clears_R2: assert property (@(posedge clk)
    $past(rst) |-> (countOut == '0 && pwmOut == '0));

  assert_wrap_sets_all_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && countOut == '0) |=> (&pwmOut));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_rise_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      $rose(pwmOut[ch]) |-> ($past(enable) && $past(countOut) == '0));

    assert_fall_at_match_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(pwmOut[ch]) |-> ($past(enable) && $past(countOut) != '0));
  end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chkInst (
  .clk      (clk),
  .rst      (rst),
  .enable   (enable),
  .levels   (levels),
  .pwmOut   (pwmOut),
  .countOut (countOut)
);

// File: tb/pwm_bank_test.sv
module pwm_bank_test;

  localparam int NUM_CH = 8;
  localparam int CNT_W  = 8;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    enable = 1'b0;
  logic [NUM_CH*CNT_W-1:0] levels = '0;
  logic [NUM_CH-1:0]       pwmOut;
  logic [CNT_W-1:0]        countOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model state
  logic [CNT_W-1:0] activeL [NUM_CH];
  bit primed = 0;

  pwm_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .levels   (levels),
    .pwmOut   (pwmOut),
    .countOut (countOut)
  );

  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NUM_CH-1:0] expectedPwm();
    logic [NUM_CH-1:0] e;
    for (int i = 0; i < NUM_CH; i++) begin
      e[i] = primed && (activeL[i] == 0 ||
             (countOut >= 1 && countOut <= activeL[i]));
    end
    return e;
  endfunction

  function automatic void clearModel();
    primed = 0;
    for (int i = 0; i < NUM_CH; i++) activeL[i] = '0;
  endfunction

  // One clock: predict, advance, compare one ns after the edge
  task automatic stepCheck(string cntReq, string pwmReq);
    logic [CNT_W-1:0] nxt [NUM_CH];
    logic [CNT_W-1:0] prevCnt;
    bit wrapNow;
    bit en;
    en = enable;
    prevCnt = countOut;
    wrapNow = en && (countOut == 0);
    for (int i = 0; i < NUM_CH; i++)
      nxt[i] = wrapNow ? levels[i*CNT_W +: CNT_W] : activeL[i];
    @(posedge clk);
    #1;
    if (wrapNow) primed = 1;
    for (int i = 0; i < NUM_CH; i++) activeL[i] = nxt[i];
    check(cntReq, countOut, en ? CNT_W'(prevCnt + 1) : prevCnt);
    check(pwmReq, pwmOut, expectedPwm());
  endtask

  task automatic setLevel(int ch, int val);
    levels[ch*CNT_W +: CNT_W] = CNT_W'(val);
  endtask

  task automatic testReset();
    rst = 1'b1;
    enable = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R2 count", countOut, 0);
    check("R2 pwm", pwmOut, 0);
    rst = 1'b0;
    clearModel();
  endtask

  task automatic testDutyMix();
    // levels 0,1,2,127,128,254,255,37
    setLevel(0, 0);   setLevel(1, 1);   setLevel(2, 2);   setLevel(3, 127);
    setLevel(4, 128); setLevel(5, 254); setLevel(6, 255); setLevel(7, 37);
    enable = 1'b1;
    repeat (600) stepCheck("R1", "R8 R4 R5 R6 R9");
  endtask

  task automatic testHold();
    while (countOut != 8'd90) stepCheck("R1", "R8");
    enable = 1'b0;
    repeat (12) stepCheck("R3", "R3");
    enable = 1'b1;
    repeat (20) stepCheck("R1", "R8");
  endtask

  task automatic testLateLevel();
    setLevel(0, 100);
    setLevel(3, 10);
    while (countOut != 8'd50) stepCheck("R1", "R7");
    // mid-period: lower ch0 below the count, raise ch3 above it
    setLevel(0, 20);
    setLevel(3, 200);
    repeat (400) stepCheck("R1", "R7 R9");
  endtask

  task automatic testAsyncReset();
    while (countOut != 8'd30) stepCheck("R1", "R8");
    rst = 1'b1;
    #1;
    check("R2 async count", countOut, 0);
    check("R2 async pwm", pwmOut, 0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    clearModel();
    setLevel(1, 5);
    repeat (300) stepCheck("R1", "R8 R2");
  endtask

  initial begin
    clearModel();
    testReset();
    testDutyMix();
    testHold();
    testLateLevel();
    testAsyncReset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule